// File: doc/BRIEF.md
# Five-Port Dimension-Ordered Mesh Router

This block is the packet switch that sits at one node of a two-dimensional mesh network-on-chip. It has five input ports and five output ports: four face the neighbouring nodes (North, East, West, South) and one faces the local processing element. Each packet is a single flit. The flit carries the destination node coordinates in its header bits and a payload below them.

The switch routes each flit along X until the column matches, then along Y until the row matches. It hands the flit to the Local output once both match. The node's own coordinates are elaboration parameters. East is increasing X and South is increasing Y.

Packets from a neighbour are queued in a small input FIFO. The Local input is not buffered: the local element holds its flit on the port until it is taken. Every port uses a valid/ready handshake. When several inputs want the same output, a per-output round-robin arbiter picks one of them.

Top module: `mesh_router`

## Requirements
- R1: Port index encoding on every per-port vector is 0 North, 1 East, 2 West, 3 South, 4 Local. Port p uses flit slice [p*FW +: FW], where FW = X_W + Y_W + DATA_W. Within a flit, destination X occupies the top X_W bits, destination Y the next Y_W bits, and the payload the low DATA_W bits.
- R2: When destination X is greater than the own X, the flit leaves on East (1). When it is smaller, the flit leaves on West (2). Destination Y has no effect in either case.
- R3: When destination X equals the own X, a flit with destination Y greater than the own Y leaves on South (3), and one with a smaller destination Y leaves on North (0).
- R4: When both destination coordinates equal the own coordinates, the flit leaves on Local (4) with its payload unchanged.
- R5: Each neighbour input has a FIFO of FIFO_DEPTH entries (4 by default). Its in_ready_o bit is high exactly when the FIFO is not full. A flit accepted at a clock edge is offered on its output from the next cycle on. Flits from one input leave in arrival order.
- R6: The Local input is unbuffered. Its flit is offered on the chosen output in the same cycle it is presented. in_ready_o[4] is high only in a cycle in which that flit transfers.
- R7: Each output has its own round-robin pointer, which is North after reset. Among the requesting inputs, the output grants the first one found from the pointer upward in index order, wrapping from 4 to 0. After a transfer the pointer moves to the index just after the winner. Without a transfer the pointer does not change.
- R8: A flit moves only in a cycle where its output's out_ready_i bit is high. While that bit is low, the output keeps out_valid_o high and the flit stays at the head of its input.
- R9: Each output carries at most one flit per cycle, and each input is granted to at most one output per cycle. Flits bound for different outputs move in the same cycle.
- R10: While rst_ni is low and right after it rises, every out_valid_o bit is low, the FIFOs are empty, and in_ready_o is high on all four neighbour inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 5 | Per-input flit valid, indexed N,E,W,S,L |
| in_flit_i | input | 5*FW | Per-input flit, port p at [p*FW +: FW] |
| in_ready_o | output | 5 | Per-input ready |
| out_valid_o | output | 5 | Per-output flit valid |
| out_flit_o | output | 5*FW | Per-output flit, port p at [p*FW +: FW] |
| out_ready_i | input | 5 | Per-output ready from the downstream node |

## Verification
A flit presented on a neighbour input is written into its FIFO at the next rising edge and appears on its output in the following cycle. The bench therefore checks neighbour traffic at the falling edge after the accepting edge. A Local flit appears combinationally, so the bench checks it a moment after driving it and before the next rising edge. Each step of the arbitration and back-pressure sequences takes one rising edge. The bench checks the expected winner or stall at the falling edge in between, and checks that the outputs are idle at the falling edge after the last transfer.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  localparam int NUM_PORTS = 5;

  typedef enum logic [2:0] {
    PORT_N = 3'd0,
    PORT_E = 3'd1,
    PORT_W = 3'd2,
    PORT_S = 3'd3,
    PORT_L = 3'd4
  } port_e;
endpackage

// File: rtl/mesh_fifo.sv
module mesh_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rd_q];
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && valid_o;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= bump(wr_q);
      if (pop_ok)  rd_q <= bump(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= data_i;
  end

  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o);

  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/mesh_route.sv
module mesh_route
  import mesh_pkg::*;
#(
  parameter int X_W  = 2,
  parameter int Y_W  = 2,
  parameter int MY_X = 1,
  parameter int MY_Y = 1
) (
  input  logic [X_W-1:0] dst_x_i,
  input  logic [Y_W-1:0] dst_y_i,
  output port_e          dir_o
);
  localparam logic [X_W-1:0] OWN_X = X_W'(MY_X);
  localparam logic [Y_W-1:0] OWN_Y = Y_W'(MY_Y);

  // X resolved first, Y only once the column matches
  always_comb begin
    if (dst_x_i > OWN_X)      dir_o = PORT_E;
    else if (dst_x_i < OWN_X) dir_o = PORT_W;
    else if (dst_y_i > OWN_Y) dir_o = PORT_S;
    else if (dst_y_i < OWN_Y) dir_o = PORT_N;
    else                      dir_o = PORT_L;
  end
endmodule

// File: rtl/mesh_rr_arb.sv
module mesh_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, win;
  logic          found;
  int            idx;

  always_comb begin
    gnt_o = '0;
    win   = '0;
    found = 1'b0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        win        = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R7
  grant_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  // R7
  adv_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (req_i != '0));
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_pkg::*;
#(
  parameter int X_W        = 2,
  parameter int Y_W        = 2,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 1,
  parameter int FW         = X_W + Y_W + DATA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PORTS-1:0]      in_valid_i,
  input  logic [NUM_PORTS*FW-1:0]   in_flit_i,
  output logic [NUM_PORTS-1:0]      in_ready_o,
  output logic [NUM_PORTS-1:0]      out_valid_o,
  output logic [NUM_PORTS*FW-1:0]   out_flit_o,
  input  logic [NUM_PORTS-1:0]      out_ready_i
);
  localparam int NP    = NUM_PORTS;
  localparam int LOCAL = int'(PORT_L);

  logic [FW-1:0]   head_flit [NP];
  logic [NP-1:0]   head_vld;
  port_e           head_dir  [NP];
  logic [NP-1:0]   pop;
  logic [NP-1:0]   req       [NP];
  logic [NP-1:0]   gnt       [NP];
  logic [NP-1:0]   gnt_col   [NP];
  logic [FW-1:0]   out_flit  [NP];
  logic [NP-1:0]   xfer;

  for (genvar i = 0; i < NP; i++) begin : g_in
    if (i != LOCAL) begin : g_buf
      logic full;
      mesh_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (in_valid_i[i]),
        .data_i  (in_flit_i[i*FW +: FW]),
        .full_o  (full),
        .pop_i   (pop[i]),
        .valid_o (head_vld[i]),
        .data_o  (head_flit[i])
      );
      assign in_ready_o[i] = !full;
    end else begin : g_direct
      assign head_vld[i]   = in_valid_i[i];
      assign head_flit[i]  = in_flit_i[i*FW +: FW];
      assign in_ready_o[i] = pop[i];
    end

    mesh_route #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .dst_x_i (head_flit[i][FW-1 -: X_W]),
      .dst_y_i (head_flit[i][FW-X_W-1 -: Y_W]),
      .dir_o   (head_dir[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req[o][i] = head_vld[i] && (head_dir[i] == port_e'(o));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    assign out_valid_o[o] = |req[o];
    assign xfer[o]        = out_valid_o[o] && out_ready_i[o];

    mesh_rr_arb #(.N(NP)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req[o]),
      .adv_i  (xfer[o]),
      .gnt_o  (gnt[o])
    );

    // R8 (sender keeps valid until ready, as the handshake requires)
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && !out_ready_i[o]) |=> out_valid_o[o]);
  end

  // crossbar: granted head onto each output
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      out_flit[o] = '0;
      for (int i = 0; i < NP; i++)
        if (gnt[o][i]) out_flit[o] = head_flit[i];
      out_flit_o[o*FW +: FW] = out_flit[o];
    end
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < NP; i++) begin
      for (int o = 0; o < NP; o++) begin
        gnt_col[i][o] = gnt[o][i];
        if (gnt[o][i] && out_ready_i[o]) pop[i] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_chk
    // R9
    one_out_per_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_col[i]));
  end
endmodule

// File: tb/mesh_router_bench.sv
module mesh_router_bench;
  localparam int FW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [4:0]    in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [5*FW-1:0] in_flit = '0, out_flit;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  mesh_router u_mesh_router (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_flit_i(in_flit), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_flit_o(out_flit), .out_ready_i(out_ready)
  );

  function automatic logic [FW-1:0] mk(int x, int y, int p);
    logic [1:0] xb = x[1:0];
    logic [1:0] yb = y[1:0];
    logic [7:0] pb = p[7:0];
    return {xb, yb, pb};
  endfunction

  // own node is (1,1)
  function automatic int exp_port(int x, int y);
    if (x > 1) return 1;
    if (x < 1) return 2;
    if (y > 1) return 3;
    if (y < 1) return 0;
    return 4;
  endfunction

  task automatic chk(bit ok, string r, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", r, act, expv);
    end
  endtask

  task automatic set_in(int p, bit v, logic [FW-1:0] f);
    in_valid[p] = v;
    in_flit[p*FW +: FW] = f;
  endtask

  task automatic check_out(int ep, logic [7:0] pl, string r);
    logic [4:0] ev = 5'b1 << ep;
    chk(out_valid == ev, r, int'(out_valid), int'(ev));
    chk(out_flit[ep*FW +: 8] == pl, r, int'(out_flit[ep*FW +: 8]), int'(pl));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    in_valid = '0;
    out_ready = '1;
    #1;
    chk(out_valid == 5'b0, "R10", int'(out_valid), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(out_valid == 5'b0, "R10", int'(out_valid), 0);
    chk(in_ready[3:0] == 4'hF, "R10", int'(in_ready[3:0]), 15);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();

    // R1 R2 R3 R4 R5 R6: routing sweep over every input and destination
    for (int p = 0; p < 5; p++)
      for (int x = 0; x < 4; x++)
        for (int y = 0; y < 4; y++) begin
          logic [7:0] pl = 8'(p * 16 + x * 4 + y);
          string r = (x != 1) ? "R2" : ((y != 1) ? "R3" : "R4");
          @(negedge clk);
          chk(out_valid == 5'b0, "R9", int'(out_valid), 0);
          set_in(p, 1'b1, mk(x, y, pl));
          if (p == 4) begin
            #1;
            check_out(exp_port(x, y), pl, (r == "R4") ? "R6" : r);
          end
          @(posedge clk);
          @(negedge clk);
          set_in(p, 1'b0, '0);
          if (p != 4) begin
            #1;
            check_out(exp_port(x, y), pl, (r == "R4") ? "R5" : r);
          end
          @(posedge clk);
        end

    // R9: four inputs to four distinct outputs in one cycle
    @(negedge clk);
    set_in(0, 1'b1, mk(3, 1, 8'hC0));
    set_in(1, 1'b1, mk(0, 1, 8'hC1));
    set_in(2, 1'b1, mk(1, 3, 8'hC2));
    set_in(3, 1'b1, mk(1, 1, 8'hC3));
    @(posedge clk);
    @(negedge clk);
    in_valid = '0;
    #1;
    chk(out_valid == 5'b11110, "R9", int'(out_valid), 'h1e);
    chk(out_flit[1*FW +: 8] == 8'hC0, "R9", int'(out_flit[1*FW +: 8]), 'hC0);
    chk(out_flit[2*FW +: 8] == 8'hC1, "R9", int'(out_flit[2*FW +: 8]), 'hC1);
    chk(out_flit[3*FW +: 8] == 8'hC2, "R9", int'(out_flit[3*FW +: 8]), 'hC2);
    chk(out_flit[4*FW +: 8] == 8'hC3, "R9", int'(out_flit[4*FW +: 8]), 'hC3);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(out_valid == 5'b0, "R9", int'(out_valid), 0);

    // R5 R8: fill North FIFO while East output stalls
    out_ready[1] = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      set_in(0, 1'b1, mk(3, 0, 8'hD0 + k));
      #1;
      chk(in_ready[0] == (k < 4), "R5", int'(in_ready[0]), int'(k < 4));
      @(posedge clk);
    end
    @(negedge clk);
    set_in(0, 1'b0, '0);
    repeat (2) begin
      #1;
      check_out(1, 8'hD0, "R8");
      @(negedge clk);
    end
    out_ready[1] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      check_out(1, 8'hD0 + 8'(k), "R5");
      @(posedge clk);
      @(negedge clk);
    end
    #1;
    chk(out_valid == 5'b0, "R8", int'(out_valid), 0);

    // R7 R6: five-way contention on Local from the reset pointer
    do_reset();
    @(negedge clk);
    out_ready[4] = 1'b0;
    for (int i = 0; i < 5; i++) set_in(i, 1'b1, mk(1, 1, 8'hA0 + i));
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 4; i++) set_in(i, 1'b0, '0);
    #1;
    chk(in_ready[4] == 1'b0, "R6", int'(in_ready[4]), 0);
    check_out(4, 8'hA0, "R8");
    @(posedge clk);
    @(negedge clk);
    out_ready[4] = 1'b1;
    for (int s = 0; s < 5; s++) begin
      #1;
      check_out(4, 8'hA0 + 8'(s), "R7");
      if (s == 4) chk(in_ready[4] == 1'b1, "R6", int'(in_ready[4]), 1);
      @(posedge clk);
      @(negedge clk);
      if (s == 4) set_in(4, 1'b0, '0);
    end
    #1;
    chk(out_valid == 5'b0, "R7", int'(out_valid), 0);

    // R7: a single West transfer moves the pointer to South, then N, W, L contend
    set_in(2, 1'b1, mk(1, 1, 8'hB0));
    @(posedge clk);
    @(negedge clk);
    set_in(2, 1'b0, '0);
    #1;
    check_out(4, 8'hB0, "R7");
    @(posedge clk);
    @(negedge clk);
    out_ready[4] = 1'b0;
    set_in(0, 1'b1, mk(1, 1, 8'hB1));
    set_in(2, 1'b1, mk(1, 1, 8'hB2));
    set_in(4, 1'b1, mk(1, 1, 8'hB3));
    @(posedge clk);
    @(negedge clk);
    set_in(0, 1'b0, '0);
    set_in(2, 1'b0, '0);
    out_ready[4] = 1'b1;
    begin
      logic [7:0] ord [3] = '{8'hB3, 8'hB1, 8'hB2};
      for (int s = 0; s < 3; s++) begin
        #1;
        check_out(4, ord[s], "R7");
        @(posedge clk);
        @(negedge clk);
        if (s == 0) set_in(4, 1'b0, '0);
      end
    end
    #1;
    chk(out_valid == 5'b0, "R7", int'(out_valid), 0);

    finish_run();
  end
endmodule